// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier Controller

This block holds a group of up to `PARTS` agents at a common synchronization point. Every agent owns one arrival lane. To enter the barrier, an agent inverts its private sense bit. It then pulses its arrival line for one cycle and presents the inverted sense on its sense lane. A single shared counter records how many distinct agents have entered the current episode.

When the arrivals in a cycle bring the counter up to the programmed group size, three things happen in that cycle. The counter returns to zero, the set of waiting agents is cleared, and the shared sense bit inverts. Each waiting agent is released once the shared sense equals its private sense. Because the sense alternates from one episode to the next, consecutive episodes reuse the same counter and each agent waits only once per episode. The state is a counter, a sense bit, one waiting bit per lane and the group-size register.

The group size can be reprogrammed. A new size takes effect at once if no episode is open. Otherwise it is held back and installed in the cycle that completes the open episode. Two kinds of faulty arrival are reported on per-lane error pulses and are not counted: an agent that arrives twice within one episode, and an agent whose presented sense does not match the episode in progress.

Top module: `sense_barrier`

## Requirements
- R1: After reset the arrival count is 0, the shared sense is 0, the group size equals `RESET_PARTS`, no lane is waiting, no write is pending, and `done_o` and both error vectors are 0.
- R2: An arrival on lane i counts when its sense equals the inverse of the shared sense and lane i is not already waiting. In the next cycle `arrive_count_o` has risen by the number of such lanes in that cycle, and their `waiting_o` bits are set.
- R3: When count plus counted arrivals reaches or exceeds the group size, the next cycle shows count 0, no lanes waiting, the shared sense inverted and `done_o` high for exactly one cycle. All arrivals counted in the completing cycle belong to the completing episode. The shared sense changes at no other time.
- R4: An arrival on a lane whose `waiting_o` bit is already set, with the correct sense, raises that lane's `dup_err_o` bit for one cycle and is not counted.
- R5: An arrival whose sense equals the shared sense raises that lane's `sense_err_o` bit for one cycle and is not counted; it never raises `dup_err_o`.
- R6: A legal size write in a cycle with count 0 and no counted arrivals sets `size_o` in the next cycle.
- R7: A legal size write in any other non-completing cycle leaves `size_o` unchanged and raises `cfg_pending_o`. The latest deferred value is installed in the completing cycle. A write in the completing cycle itself is installed directly, and in both cases `cfg_pending_o` is low after completion.
- R8: Size writes of 0 or of a value above `PARTS` are ignored, so `size_o` always stays within 1..`PARTS`.
- R9: Back-to-back episodes alternate the required arrival sense: after a completion that set the shared sense to s, arrivals count only with sense not s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | PARTS | One-cycle arrival pulse per lane |
| sense_i | input | PARTS | Private sense presented with each arrival |
| cfg_wr_i | input | 1 | Group-size write strobe |
| cfg_size_i | input | CNT_W | Requested group size |
| global_sense_o | output | 1 | Shared sense bit |
| done_o | output | 1 | One-cycle pulse after each completion |
| arrive_count_o | output | CNT_W | Agents counted in the open episode |
| size_o | output | CNT_W | Group size in force |
| cfg_pending_o | output | 1 | A size write is waiting for completion |
| waiting_o | output | PARTS | Lanes counted in the open episode |
| dup_err_o | output | PARTS | Repeated-arrival error pulse per lane |
| sense_err_o | output | PARTS | Wrong-sense arrival error pulse per lane |

## Verification
The stimulus covers the cases a weak design gets wrong. A repeated arrival in the cycle that completes the episode must be rejected, or the episode would close one agent early. Several lanes can arrive at once and overshoot the group size; a design that missed this would never complete, and the sense would stop toggling. A size write arriving while agents wait must be held back, because applying it early would release the group at the wrong count. A write in the completing cycle must not be lost, and a write in an idle cycle that also carries an arrival must be deferred. The sense alternation across episodes is exercised, as are illegal sizes and a reset that arrives with a write pending and agents waiting.

// File: rtl/sense_barrier_pkg.sv
// Package: shared types for the sense-reversing barrier.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package sense_barrier_pkg;

    // Classification of one lane's activity in one cycle.
    typedef enum logic [1:0] {
        ARR_IDLE      = 2'd0,
        ARR_COUNTED   = 2'd1,
        ARR_REPEAT    = 2'd2,
        ARR_BAD_SENSE = 2'd3
    } arrival_kind_e;

    // Decide how a lane's activity is treated this cycle.
    function automatic arrival_kind_e classify_arrival(
        input logic pulse,
        input logic lane_sense,
        input logic shared_sense,
        input logic already_waiting
    );
        if (!pulse)
            return ARR_IDLE;
        else if (lane_sense == shared_sense)
            return ARR_BAD_SENSE;
        else if (already_waiting)
            return ARR_REPEAT;
        else
            return ARR_COUNTED;
    endfunction

endpackage

// File: rtl/barrier_arrival_filter.sv
// Module: barrier_arrival_filter
// Classifies each lane's arrival against the shared sense and the set of
// lanes already waiting. It keeps the waiting set, produces the number of
// arrivals counted this cycle, and registers the per-lane error pulses.
// Assumes: complete_i is a same-cycle decision that depends on
// counted_o, so the waiting set is updated only at the clock edge.
module barrier_arrival_filter
    import sense_barrier_pkg::*;
#(
    parameter int PARTS = 8,
    parameter int CNT_W = $clog2(PARTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PARTS-1:0] arrive_i,
    input  logic [PARTS-1:0] sense_i,
    input  logic             shared_sense_i,
    input  logic             complete_i,
    output logic [CNT_W-1:0] counted_o,
    output logic [PARTS-1:0] waiting_o,
    output logic [PARTS-1:0] dup_err_o,
    output logic [PARTS-1:0] sense_err_o
);

    logic [PARTS-1:0] waiting_q;
    logic [PARTS-1:0] take_vec;
    logic [PARTS-1:0] repeat_vec;
    logic [PARTS-1:0] badsense_vec;

    // One classifier per lane.
    for (genvar g = 0; g < PARTS; g++) begin : g_lane
        arrival_kind_e kind;

        // Classify this lane's activity for the current cycle.
        always_comb begin
            kind = classify_arrival(arrive_i[g], sense_i[g],
                                    shared_sense_i, waiting_q[g]);
        end

        assign take_vec[g]     = (kind == ARR_COUNTED);
        assign repeat_vec[g]   = (kind == ARR_REPEAT);
        assign badsense_vec[g] = (kind == ARR_BAD_SENSE);
    end

    // Sum the lanes whose arrival counts this cycle.
    always_comb begin
        counted_o = '0;
        for (int i = 0; i < PARTS; i++)
            counted_o = counted_o + CNT_W'(take_vec[i]);
    end

    // Keep the waiting set: add counted lanes, clear it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiting_q <= '0;
        else if (complete_i)
            waiting_q <= '0;
        else
            waiting_q <= waiting_q | take_vec;
    end

    // Register the per-lane error pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_err_o   <= '0;
            sense_err_o <= '0;
        end else begin
            dup_err_o   <= repeat_vec;
            sense_err_o <= badsense_vec;
        end
    end

    assign waiting_o = waiting_q;

endmodule

// File: rtl/barrier_episode_counter.sv
// Module: barrier_episode_counter
// Holds the shared arrival counter and the shared sense bit. It detects
// completion when the counter plus this cycle's counted arrivals reaches
// the group size. In that cycle the counter reloads to zero and the sense
// inverts.
// Assumes: size_i is never zero; counted_i never exceeds the lane count.
module barrier_episode_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] counted_i,
    input  logic [CNT_W-1:0] size_i,
    output logic             complete_o,
    output logic             idle_o,
    output logic [CNT_W-1:0] count_o,
    output logic             shared_sense_o,
    output logic             done_o
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic             sense_q;
    logic [SUM_W-1:0] next_total;

    // Running total if this cycle's arrivals were added.
    always_comb begin
        next_total = SUM_W'(count_q) + SUM_W'(counted_i);
    end

    assign complete_o = (counted_i != '0) && (next_total >= SUM_W'(size_i));
    assign idle_o     = (count_q == '0) && (counted_i == '0);

    // Advance the counter, reloading it to zero on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (complete_o)
            count_q <= '0;
        else
            count_q <= next_total[CNT_W-1:0];
    end

    // Invert the shared sense and pulse done on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            sense_q <= sense_q ^ complete_o;
            done_o  <= complete_o;
        end
    end

    assign count_o        = count_q;
    assign shared_sense_o = sense_q;

endmodule

// File: rtl/barrier_size_reg.sv
// Module: barrier_size_reg
// Holds the group size in force. A legal write applies at once when no
// episode is open, or in the completing cycle. Any other legal write is
// parked and installed at the next completion, and the latest write wins.
// Illegal values (zero or above PARTS) are dropped.
// Assumes: complete_i and idle_i are never both high.
module barrier_size_reg #(
    parameter int PARTS       = 8,
    parameter int CNT_W       = $clog2(PARTS + 1),
    parameter int RESET_PARTS = PARTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             complete_i,
    input  logic             idle_i,
    output logic [CNT_W-1:0] size_o,
    output logic             pending_o
);

    localparam logic [CNT_W-1:0] MAX_SIZE   = CNT_W'(PARTS);
    localparam logic [CNT_W-1:0] RESET_SIZE = CNT_W'(RESET_PARTS);

    logic             legal;
    logic [CNT_W-1:0] size_q;
    logic [CNT_W-1:0] parked_q;
    logic             parked_vld_q;

    // A write is legal only for sizes 1..PARTS.
    always_comb begin
        legal = wr_i && (val_i != '0) && (val_i <= MAX_SIZE);
    end

    // Apply, park or install the group size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q       <= RESET_SIZE;
            parked_q     <= RESET_SIZE;
            parked_vld_q <= 1'b0;
        end else if (legal && (complete_i || idle_i)) begin
            size_q       <= val_i;
            parked_vld_q <= 1'b0;
        end else if (legal) begin
            parked_q     <= val_i;
            parked_vld_q <= 1'b1;
        end else if (complete_i && parked_vld_q) begin
            size_q       <= parked_q;
            parked_vld_q <= 1'b0;
        end
    end

    assign size_o    = size_q;
    assign pending_o = parked_vld_q;

endmodule

// File: rtl/sense_barrier.sv
// Module: sense_barrier (top)
// Centralized barrier for up to PARTS lanes. One shared counter and one
// shared sense bit serve every episode. Lanes enter by pulsing arrive_i
// with their inverted private sense, and they are released when
// global_sense_o equals that sense.
// Assumes: RESET_PARTS is within 1..PARTS.
module sense_barrier #(
    parameter int PARTS       = 8,
    parameter int RESET_PARTS = PARTS,
    parameter int CNT_W       = $clog2(PARTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PARTS-1:0] arrive_i,
    input  logic [PARTS-1:0] sense_i,
    input  logic             cfg_wr_i,
    input  logic [CNT_W-1:0] cfg_size_i,
    output logic             global_sense_o,
    output logic             done_o,
    output logic [CNT_W-1:0] arrive_count_o,
    output logic [CNT_W-1:0] size_o,
    output logic             cfg_pending_o,
    output logic [PARTS-1:0] waiting_o,
    output logic [PARTS-1:0] dup_err_o,
    output logic [PARTS-1:0] sense_err_o
);

    logic [CNT_W-1:0] counted;
    logic             complete;
    logic             idle;

    barrier_arrival_filter #(
        .PARTS (PARTS),
        .CNT_W (CNT_W)
    ) u_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .arrive_i       (arrive_i),
        .sense_i        (sense_i),
        .shared_sense_i (global_sense_o),
        .complete_i     (complete),
        .counted_o      (counted),
        .waiting_o      (waiting_o),
        .dup_err_o      (dup_err_o),
        .sense_err_o    (sense_err_o)
    );

    barrier_episode_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk            (clk),
        .rst_n          (rst_n),
        .counted_i      (counted),
        .size_i         (size_o),
        .complete_o     (complete),
        .idle_o         (idle),
        .count_o        (arrive_count_o),
        .shared_sense_o (global_sense_o),
        .done_o         (done_o)
    );

    barrier_size_reg #(
        .PARTS       (PARTS),
        .CNT_W       (CNT_W),
        .RESET_PARTS (RESET_PARTS)
    ) u_size (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .val_i      (cfg_size_i),
        .complete_i (complete),
        .idle_i     (idle),
        .size_o     (size_o),
        .pending_o  (cfg_pending_o)
    );

endmodule

// File: rtl/sense_barrier_checker.sv
// Module: sense_barrier_checker
// Temporal checks on the barrier's ports, attached to every instance of
// sense_barrier by the bind at the bottom of this file.
// Assumes: rst_n is low from time zero until the first clock edges.
module sense_barrier_checker #(
    parameter int PARTS = 8,
    parameter int CNT_W = $clog2(PARTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             global_sense_o,
    input logic             done_o,
    input logic [CNT_W-1:0] arrive_count_o,
    input logic [CNT_W-1:0] size_o,
    input logic             cfg_pending_o,
    input logic [PARTS-1:0] waiting_o,
    input logic [PARTS-1:0] dup_err_o,
    input logic [PARTS-1:0] sense_err_o
);

    assert_count_below_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_count_o < size_o);

    assert_waiting_matches_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(waiting_o) == int'(arrive_count_o));

    assert_done_flips_sense_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (global_sense_o != $past(global_sense_o)));

    assert_sense_moves_only_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (global_sense_o != $past(global_sense_o)) |-> done_o);

    assert_done_clears_episode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (arrive_count_o == '0 && waiting_o == '0));

    assert_repeat_was_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_err_o & ~$past(waiting_o)) == '0);

    assert_errors_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_err_o & sense_err_o) == '0);

    assert_size_change_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_o != $past(size_o)) |-> (done_o || $past(arrive_count_o) == '0));

    assert_pending_clear_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cfg_pending_o);

    assert_size_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        size_o != '0 && size_o <= CNT_W'(PARTS));

endmodule

bind sense_barrier sense_barrier_checker #(.PARTS(PARTS)) u_checker (.*);

// File: tb/test_sense_barrier.sv
// Bench for sense_barrier: a vector table walked by one loop, then directed
// reset tests. Inputs change on the falling edge, and outputs are sampled
// on the next falling edge, after the one rising edge that registers them.
module test_sense_barrier;

    localparam int P = 4;
    localparam int W = $clog2(P + 1);

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] arr;
        logic [3:0] sns;
        logic       wr;
        logic [2:0] val;
        logic [2:0] cnt;
        logic       gs;
        logic       done;
        logic [2:0] size;
        logic       pend;
        logic [3:0] wait_m;
        logic [3:0] dup;
        logic [3:0] serr;
    } vec_t;

    localparam int NV = 19;
    // Fields: req arr sns wr val | cnt gs done size pend wait dup serr
    localparam vec_t VECS [NV] = '{
        '{4'd2, 4'b0001, 4'b0001, 1'b0, 3'd0, 3'd1, 1'b0, 1'b0, 3'd4, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R2 first arrival
        '{4'd4, 4'b0001, 4'b0001, 1'b0, 3'd0, 3'd1, 1'b0, 1'b0, 3'd4, 1'b0, 4'b0001, 4'b0001, 4'b0000}, // R4 repeat
        '{4'd5, 4'b0010, 4'b0000, 1'b0, 3'd0, 3'd1, 1'b0, 1'b0, 3'd4, 1'b0, 4'b0001, 4'b0000, 4'b0010}, // R5 wrong sense
        '{4'd2, 4'b0110, 4'b0110, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0, 3'd4, 1'b0, 4'b0111, 4'b0000, 4'b0000}, // R2 two at once
        '{4'd7, 4'b0000, 4'b0000, 1'b1, 3'd2, 3'd3, 1'b0, 1'b0, 3'd4, 1'b1, 4'b0111, 4'b0000, 4'b0000}, // R7 deferred
        '{4'd3, 4'b1000, 4'b1000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R3 complete
        '{4'd3, 4'b0000, 4'b0000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R3 done one cycle
        '{4'd9, 4'b0001, 4'b0000, 1'b0, 3'd0, 3'd1, 1'b1, 1'b0, 3'd2, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R9 inverted sense
        '{4'd4, 4'b0101, 4'b0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R4 repeat in completing cycle
        '{4'd8, 4'b0000, 4'b0000, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R8 zero
        '{4'd8, 4'b0000, 4'b0000, 1'b1, 3'd5, 3'd0, 1'b0, 1'b0, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R8 too large
        '{4'd6, 4'b0000, 4'b0000, 1'b1, 3'd3, 3'd0, 1'b0, 1'b0, 3'd3, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R6 idle write
        '{4'd3, 4'b1111, 4'b1111, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 3'd3, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R3 overshoot
        '{4'd7, 4'b0011, 4'b0000, 1'b1, 3'd1, 3'd2, 1'b1, 1'b0, 3'd3, 1'b1, 4'b0011, 4'b0000, 4'b0000}, // R7 write with arrivals
        '{4'd7, 4'b0000, 4'b0000, 1'b1, 3'd4, 3'd2, 1'b1, 1'b0, 3'd3, 1'b1, 4'b0011, 4'b0000, 4'b0000}, // R7 latest wins
        '{4'd7, 4'b0100, 4'b0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R7 installed
        '{4'd2, 4'b0111, 4'b0111, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0, 3'd4, 1'b0, 4'b0111, 4'b0000, 4'b0000}, // R2 three at once
        '{4'd7, 4'b1000, 4'b1000, 1'b1, 3'd2, 3'd0, 1'b1, 1'b1, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R7 write in completing cycle
        '{4'd9, 4'b0011, 4'b0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000}  // R9 sense back to 0
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] arrive_i = '0;
    logic [P-1:0] sense_i = '0;
    logic         cfg_wr_i = 1'b0;
    logic [W-1:0] cfg_size_i = '0;
    logic         global_sense_o;
    logic         done_o;
    logic [W-1:0] arrive_count_o;
    logic [W-1:0] size_o;
    logic         cfg_pending_o;
    logic [P-1:0] waiting_o;
    logic [P-1:0] dup_err_o;
    logic [P-1:0] sense_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sense_barrier #(.PARTS(P)) i_sense_barrier (
        .clk            (clk),
        .rst_n          (rst_n),
        .arrive_i       (arrive_i),
        .sense_i        (sense_i),
        .cfg_wr_i       (cfg_wr_i),
        .cfg_size_i     (cfg_size_i),
        .global_sense_o (global_sense_o),
        .done_o         (done_o),
        .arrive_count_o (arrive_count_o),
        .size_o         (size_o),
        .cfg_pending_o  (cfg_pending_o),
        .waiting_o      (waiting_o),
        .dup_err_o      (dup_err_o),
        .sense_err_o    (sense_err_o)
    );

    task automatic check(input string what, input int req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: the full reset state.
    task automatic check_reset_state();
        check("count", 1, int'(arrive_count_o), 0);
        check("sense", 1, int'(global_sense_o), 0);
        check("size", 1, int'(size_o), P);
        check("pending", 1, int'(cfg_pending_o), 0);
        check("waiting", 1, int'(waiting_o), 0);
        check("done", 1, int'(done_o), 0);
        check("errors", 1, int'(dup_err_o | sense_err_o), 0);
    endtask

    task automatic idle_inputs();
        arrive_i   = '0;
        sense_i    = '0;
        cfg_wr_i   = 1'b0;
        cfg_size_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        for (int v = 0; v < NV; v++) begin
            arrive_i   = VECS[v].arr;
            sense_i    = VECS[v].sns;
            cfg_wr_i   = VECS[v].wr;
            cfg_size_i = VECS[v].val;
            @(negedge clk);
            check($sformatf("v%0d count", v), int'(VECS[v].req), int'(arrive_count_o), int'(VECS[v].cnt));
            check($sformatf("v%0d sense", v), int'(VECS[v].req), int'(global_sense_o), int'(VECS[v].gs));
            check($sformatf("v%0d done", v), int'(VECS[v].req), int'(done_o), int'(VECS[v].done));
            check($sformatf("v%0d size", v), int'(VECS[v].req), int'(size_o), int'(VECS[v].size));
            check($sformatf("v%0d pending", v), int'(VECS[v].req), int'(cfg_pending_o), int'(VECS[v].pend));
            check($sformatf("v%0d waiting", v), int'(VECS[v].req), int'(waiting_o), int'(VECS[v].wait_m));
            check($sformatf("v%0d dup", v), int'(VECS[v].req), int'(dup_err_o), int'(VECS[v].dup));
            check($sformatf("v%0d sense err", v), int'(VECS[v].req), int'(sense_err_o), int'(VECS[v].serr));
        end

        // R1: reset with an agent waiting and a deferred write parked.
        arrive_i = 4'b0001; sense_i = 4'b0001;
        @(negedge clk);
        idle_inputs();
        cfg_wr_i = 1'b1; cfg_size_i = 3'd3;
        @(negedge clk);
        check("pre-reset pending", 7, int'(cfg_pending_o), 1);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        // R2: counting resumes from zero with sense 1 after reset.
        arrive_i = 4'b1000; sense_i = 4'b1000;
        @(negedge clk);
        idle_inputs();
        check("post-reset count", 2, int'(arrive_count_o), 1);
        check("post-reset waiting", 2, int'(waiting_o), 8);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule